// File: doc/BRIEF.md
# Serial Register Target with Result-Ready Flag

This block is the host-facing register port of a sensor converter. A host frames each transaction with an active-low select. It shifts in one command byte and then one data byte. The command byte carries the direction in its top bit and a 7-bit register address in the remaining bits. The data byte is either stored into the addressed register or replaced on the output line by that register's contents. The serial clock may rest at either level between transfers. The block treats the first clock edge after select as the launch edge of a bit and the second as its capture edge. It does this by sampling select, clock and data-in with a fast system clock and counting edges, so it never looks at the resting level.

A conversion engine presents a 16-bit result with a one-cycle load strobe. The result lands in two read-only byte registers, and an active-low ready output is pulled low. The ready output returns high as soon as the command byte of a read aimed at either result byte has been fully received, even if the host then abandons the transfer. Registers other than the two result bytes are plain read/write storage.

Top module: `rtd_spi_regbank`

## Requirements
- R1: Command byte and data byte are each shifted most significant bit first. In the command byte, bit 7 = 1 selects a write and bit 7 = 0 selects a read. Bits 6..0 give the register address.
- R2: A write stores the data byte into the addressed general register once the 16th bit has been captured. The general registers are every implemented address other than 0x01 and 0x02.
- R3: A read presents the addressed register on `spi_miso` during the data byte, MSB first. Each bit is updated on the launch edge and is stable at the following capture edge.
- R4: The bit order and the launch/capture roles are the same whether `spi_sclk` rests low or high. The first edge after select is always a launch edge.
- R5: A one-cycle `result_load` copies `result_data[15:8]` to address 0x01 and `result_data[7:0]` to address 0x02. It drives `rdy_n` low in the next cycle.
- R6: `rdy_n` rises when the command byte of a read of 0x01 or 0x02 completes, even if select is released immediately afterwards. Reads of other addresses leave it unchanged.
- R7: If select is released before 16 bits are captured, no register changes.
- R8: Bits after the 16th in a transfer are ignored. There is no address auto-increment.
- R9: Writes to 0x01, 0x02 or any unimplemented address have no effect. Reads of unimplemented addresses return 0x00.
- R10: After reset `rdy_n` is 1 and all registers hold 0x00. `spi_miso_en` is 0 whenever the synchronized select is inactive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the serial lines |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_cs_n | input | 1 | Active-low transaction select |
| spi_sclk | input | 1 | Serial clock, either resting level |
| spi_mosi | input | 1 | Serial data from host |
| spi_miso | output | 1 | Serial data to host |
| spi_miso_en | output | 1 | Output enable for the data-out pad driver |
| result_load | input | 1 | One-cycle strobe that captures a new result |
| result_data | input | 16 | Conversion result, upper byte to 0x01, lower to 0x02 |
| rdy_n | output | 1 | Active-low result-ready flag |

## Verification
The bench alternates the resting clock level between transfers. A design that keyed on clock polarity rather than edge order would shift every bit by half a period and read back garbage. It abandons transfers after 7, 8, 12 and 15 bits. Clearing the flag only after a full frame would leave `rdy_n` low after the 8-bit abort, while writing on the 8th bit or on a partial frame would corrupt register 0x03. A 24-bit write checks that a trailing byte neither overwrites the target nor spills into the next address. Writes to the result bytes and to an unimplemented address check that the read-only and unimplemented paths hold.

// File: rtl/rsr_pkg.sv
package rsr_pkg;

   // direction carried in the top bit of the command byte
   typedef enum logic {
      DIR_READ  = 1'b0,
      DIR_WRITE = 1'b1
   } rsr_dir_e;

   // bits per serial byte; the command format depends on this value
   localparam int unsigned RSR_BYTE = 8;

endpackage

// File: rtl/rsr_sync.sv
module rsr_sync #(
   parameter int unsigned STAGES = 2,
   parameter int unsigned W      = 3,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   logic [W-1:0] stg [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[0] <= RST_VAL;
            else        stg[0] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[s] <= RST_VAL;
            else        stg[s] <= stg[s-1];
         end
      end
   end

   assign q = stg[STAGES-1];

endmodule

// File: rtl/rsr_shifter.sv
module rsr_shifter
   import rsr_pkg::*;
#(
   parameter int unsigned DATA_W = 8,
   localparam int unsigned AW    = DATA_W - 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_act,
   input  logic              sclk_s,
   input  logic              mosi_s,
   input  logic [DATA_W-1:0] rd_data,
   output logic              dec_stb,
   output rsr_dir_e          dec_dir,
   output logic [AW-1:0]     dec_addr,
   output logic              wr_stb,
   output logic [DATA_W-1:0] wr_data,
   output logic              miso
);

   localparam int unsigned FRAME = 2 * DATA_W;
   localparam int unsigned CW    = $clog2(FRAME + 1);
   localparam logic [CW-1:0] C_ADDR_LAST = CW'(DATA_W - 1);
   localparam logic [CW-1:0] C_DATA_FST  = CW'(DATA_W);
   localparam logic [CW-1:0] C_LAST      = CW'(FRAME - 1);
   localparam logic [CW-1:0] C_FRAME     = CW'(FRAME);

   logic              sclk_d;
   logic              cs_d;
   logic              phase;      // 0: next edge launches, 1: next edge captures
   logic [CW-1:0]     cnt;        // captured bits, saturates at FRAME
   logic [DATA_W-1:0] sh_in;
   logic [DATA_W-1:0] tx;
   logic              edge_seen;
   logic              start;
   logic              in_data;

   assign edge_seen = sclk_s ^ sclk_d;
   assign start     = cs_act & ~cs_d;
   assign in_data   = (cnt >= C_DATA_FST) && (cnt < C_FRAME);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk_d <= 1'b0;
         cs_d   <= 1'b0;
      end else begin
         sclk_d <= sclk_s;
         cs_d   <= cs_act;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase    <= 1'b0;
         cnt      <= '0;
         sh_in    <= '0;
         tx       <= '0;
         miso     <= 1'b0;
         dec_stb  <= 1'b0;
         dec_dir  <= DIR_READ;
         dec_addr <= '0;
         wr_stb   <= 1'b0;
         wr_data  <= '0;
      end else begin
         dec_stb <= 1'b0;
         wr_stb  <= 1'b0;
         if (!cs_act || start) begin
            phase <= 1'b0;
            cnt   <= '0;
            sh_in <= '0;
            miso  <= 1'b0;
         end else begin
            if (dec_stb && dec_dir == DIR_READ) begin
               tx <= rd_data;
            end
            if (edge_seen) begin
               if (!phase) begin
                  phase <= 1'b1;
                  if (in_data) begin
                     miso <= tx[DATA_W-1];
                     tx   <= {tx[DATA_W-2:0], 1'b0};
                  end
               end else begin
                  phase <= 1'b0;
                  if (cnt < C_FRAME) begin
                     sh_in <= {sh_in[DATA_W-2:0], mosi_s};
                     cnt   <= cnt + 1'b1;
                     if (cnt == C_ADDR_LAST) begin
                        dec_stb  <= 1'b1;
                        dec_dir  <= rsr_dir_e'(sh_in[DATA_W-2]);
                        dec_addr <= {sh_in[AW-2:0], mosi_s};
                     end
                     if (cnt == C_LAST) begin
                        wr_stb  <= (dec_dir == DIR_WRITE);
                        wr_data <= {sh_in[DATA_W-2:0], mosi_s};
                     end
                  end
               end
            end
         end
      end
   end

endmodule

// File: rtl/rsr_regfile.sv
module rsr_regfile #(
   parameter int unsigned DATA_W   = 8,
   parameter int unsigned NUM_REGS = 8,
   parameter int unsigned HI_ADDR  = 1,
   parameter int unsigned LO_ADDR  = 2,
   localparam int unsigned AW      = DATA_W - 1,
   localparam int unsigned RES_W   = 2 * DATA_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_stb,
   input  logic [AW-1:0]     wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [AW-1:0]     rd_addr,
   output logic [DATA_W-1:0] rd_data,
   input  logic              rd_stb,
   input  logic              res_load,
   input  logic [RES_W-1:0]  res_data,
   output logic              rdy_n
);

   localparam logic [AW-1:0] A_HI = AW'(HI_ADDR);
   localparam logic [AW-1:0] A_LO = AW'(LO_ADDR);

   logic [DATA_W-1:0] regs [NUM_REGS];

   for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
      logic [DATA_W-1:0] q;
      if (i == HI_ADDR) begin : g_hi
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        q <= '0;
            else if (res_load) q <= res_data[RES_W-1 -: DATA_W];
         end
      end else if (i == LO_ADDR) begin : g_lo
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        q <= '0;
            else if (res_load) q <= res_data[DATA_W-1:0];
         end
      end else begin : g_gen
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                             q <= '0;
            else if (wr_stb && wr_addr == AW'(i))   q <= wr_data;
         end
      end
      assign regs[i] = q;
   end

   always_comb begin
      rd_data = '0;
      for (int i = 0; i < NUM_REGS; i++) begin
         if (rd_addr == AW'(i)) rd_data = regs[i];
      end
   end

   // a new result has priority over a clear in the same cycle
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                        rdy_n <= 1'b1;
      else if (res_load)                                 rdy_n <= 1'b0;
      else if (rd_stb && (rd_addr == A_HI || rd_addr == A_LO)) rdy_n <= 1'b1;
   end

endmodule

// File: rtl/rtd_spi_regbank.sv
module rtd_spi_regbank
   import rsr_pkg::*;
#(
   parameter int unsigned DATA_W      = 8,
   parameter int unsigned NUM_REGS    = 8,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned RES_HI_ADDR = 1,
   parameter int unsigned RES_LO_ADDR = 2,
   localparam int unsigned AW         = DATA_W - 1,
   localparam int unsigned RES_W      = 2 * DATA_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             spi_cs_n,
   input  logic             spi_sclk,
   input  logic             spi_mosi,
   output logic             spi_miso,
   output logic             spi_miso_en,
   input  logic             result_load,
   input  logic [RES_W-1:0] result_data,
   output logic             rdy_n
);

   if (DATA_W != RSR_BYTE) begin : g_bad_width
      $error("rtd_spi_regbank: DATA_W must equal the serial byte size");
   end
   if (NUM_REGS < 3 || NUM_REGS > (1 << AW)) begin : g_bad_depth
      $error("rtd_spi_regbank: NUM_REGS out of range");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("rtd_spi_regbank: SYNC_STAGES must be at least 2");
   end
   if (RES_HI_ADDR == RES_LO_ADDR || RES_HI_ADDR >= NUM_REGS || RES_LO_ADDR >= NUM_REGS) begin : g_bad_res
      $error("rtd_spi_regbank: result addresses invalid");
   end

   logic [2:0]        pins_s;
   logic              cs_act;
   logic              dec_stb;
   rsr_dir_e          dec_dir;
   logic [AW-1:0]     dec_addr;
   logic              wr_stb;
   logic [DATA_W-1:0] wr_data;
   logic [DATA_W-1:0] rd_data;
   logic              rd_stb;

   rsr_sync #(
      .STAGES (SYNC_STAGES),
      .W      (3),
      .RST_VAL(3'b100)
   ) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .d    ({spi_cs_n, spi_sclk, spi_mosi}),
      .q    (pins_s)
   );

   assign cs_act = ~pins_s[2];
   assign rd_stb = dec_stb & (dec_dir == DIR_READ);

   rsr_shifter #(
      .DATA_W(DATA_W)
   ) u_shift (
      .clk     (clk),
      .rst_n   (rst_n),
      .cs_act  (cs_act),
      .sclk_s  (pins_s[1]),
      .mosi_s  (pins_s[0]),
      .rd_data (rd_data),
      .dec_stb (dec_stb),
      .dec_dir (dec_dir),
      .dec_addr(dec_addr),
      .wr_stb  (wr_stb),
      .wr_data (wr_data),
      .miso    (spi_miso)
   );

   rsr_regfile #(
      .DATA_W  (DATA_W),
      .NUM_REGS(NUM_REGS),
      .HI_ADDR (RES_HI_ADDR),
      .LO_ADDR (RES_LO_ADDR)
   ) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_stb  (wr_stb),
      .wr_addr (dec_addr),
      .wr_data (wr_data),
      .rd_addr (dec_addr),
      .rd_data (rd_data),
      .rd_stb  (rd_stb),
      .res_load(result_load),
      .res_data(result_data),
      .rdy_n   (rdy_n)
   );

   assign spi_miso_en = cs_act;

endmodule

// File: rtl/rsr_chk.sv
module rsr_chk #(
   parameter int unsigned AW = 7,
   parameter int unsigned HI = 1,
   parameter int unsigned LO = 2
) (
   input logic          clk,
   input logic          rst_n,
   input logic          res_load,
   input logic          rdy_n,
   input logic          rd_stb,
   input logic [AW-1:0] rd_addr,
   input logic          cs_act,
   input logic          wr_stb,
   input logic          miso_en
);

   p_rdy_fall_on_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
      res_load |=> !rdy_n);

   p_rdy_hold_without_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !res_load |=> !$fell(rdy_n));

   p_rdy_rise_needs_decode_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rdy_n) |-> ($past(rd_stb) &&
         ($past(rd_addr) == AW'(HI) || $past(rd_addr) == AW'(LO))));

   p_write_inside_frame_r7: assert property (@(posedge clk) disable iff (!rst_n)
      wr_stb |-> $past(cs_act));

   p_idle_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !cs_act |-> !miso_en);

endmodule

bind rtd_spi_regbank rsr_chk #(
   .AW(AW),
   .HI(RES_HI_ADDR),
   .LO(RES_LO_ADDR)
) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .res_load(result_load),
   .rdy_n   (rdy_n),
   .rd_stb  (rd_stb),
   .rd_addr (dec_addr),
   .cs_act  (cs_act),
   .wr_stb  (wr_stb),
   .miso_en (spi_miso_en)
);

// File: tb/sim_rtd_spi_regbank.sv
module sim_rtd_spi_regbank;

   localparam int HALF = 8;   // system cycles per serial half period
   localparam int NV   = 11;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cs_n = 1'b1;
   logic        sclk = 1'b0;
   logic        mosi = 1'b0;
   logic        miso;
   logic        miso_en;
   logic        res_load = 1'b0;
   logic [15:0] res_data = '0;
   logic        rdy_n;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #5 clk = ~clk;

   rtd_spi_regbank u0 (
      .clk        (clk),
      .rst_n      (rst_n),
      .spi_cs_n   (cs_n),
      .spi_sclk   (sclk),
      .spi_mosi   (mosi),
      .spi_miso   (miso),
      .spi_miso_en(miso_en),
      .result_load(res_load),
      .result_data(res_data),
      .rdy_n      (rdy_n)
   );

   // {resting clock level, command, data, expected read, compare}
   localparam logic [25:0] VEC [NV] = '{
      {1'b0, 8'h80, 8'hA5, 8'h00, 1'b0},   // R1 R2 write 0x00
      {1'b1, 8'h00, 8'hFF, 8'hA5, 1'b1},   // R3 R4 read 0x00, clock resting high
      {1'b1, 8'h85, 8'h3C, 8'h00, 1'b0},   // R2 write 0x05
      {1'b0, 8'h05, 8'h00, 8'h3C, 1'b1},   // R1 R4 read 0x05, clock resting low
      {1'b0, 8'h81, 8'hFF, 8'h00, 1'b0},   // R9 write to result byte
      {1'b1, 8'h01, 8'h00, 8'h00, 1'b1},   // R9 still zero
      {1'b0, 8'hC0, 8'h11, 8'h00, 1'b0},   // R9 write unimplemented 0x40
      {1'b1, 8'h40, 8'h00, 8'h00, 1'b1},   // R9 unimplemented reads zero
      {1'b1, 8'h00, 8'h00, 8'hA5, 1'b1},   // R9 no alias into 0x00
      {1'b0, 8'h87, 8'h5A, 8'h00, 1'b0},   // R2 write 0x07
      {1'b1, 8'h07, 8'h00, 8'h5A, 1'b1}    // R3 read 0x07
   };

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
      end
   endtask

   task automatic xfer(input bit cpol, input logic [23:0] stream, input int nbits,
                       output logic [7:0] rd);
      rd = '0;
      @(negedge clk) sclk = cpol;
      repeat (HALF) @(negedge clk);
      cs_n = 1'b0;
      repeat (HALF) @(negedge clk);
      for (int i = 0; i < nbits; i++) begin
         sclk = ~sclk;
         mosi = stream[23-i];
         repeat (HALF) @(negedge clk);
         if (i >= 8 && i < 16) rd[15-i] = miso;
         sclk = ~sclk;
         repeat (HALF) @(negedge clk);
      end
      cs_n = 1'b1;
      repeat (HALF) @(negedge clk);
   endtask

   task automatic load_result(input logic [15:0] v);
      @(negedge clk) res_data = v; res_load = 1'b1;
      @(negedge clk) res_load = 1'b0;
   endtask

   task automatic finish_run();
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog R10 actual=running expected=finished");
         finish_run();
      end
   end

   initial begin
      logic [7:0] rd;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
      check("R10 reset rdy_n", {7'd0, rdy_n}, 8'h01);
      check("R10 idle miso_en", {7'd0, miso_en}, 8'h00);

      for (int i = 0; i < NV; i++) begin
         xfer(VEC[i][25], {VEC[i][24:17], VEC[i][16:9], 8'h00}, 16, rd);
         if (VEC[i][0]) check($sformatf("R3 vector %0d", i), rd, VEC[i][8:1]);
      end
      check("R10 miso_en after transfers", {7'd0, miso_en}, 8'h00);

      // R5 result load and ready flag
      load_result(16'hBEEF);
      check("R5 rdy_n low after load", {7'd0, rdy_n}, 8'h00);
      xfer(1'b1, {8'h00, 8'h00, 8'h00}, 16, rd);
      check("R6 other read keeps rdy_n", {7'd0, rdy_n}, 8'h00);
      xfer(1'b0, {8'h01, 8'h00, 8'h00}, 16, rd);
      check("R5 upper byte", rd, 8'hBE);
      check("R6 rdy_n high after hi read", {7'd0, rdy_n}, 8'h01);
      xfer(1'b1, {8'h02, 8'h00, 8'h00}, 16, rd);
      check("R5 lower byte", rd, 8'hEF);

      // R6 clear happens at command decode
      load_result(16'h1234);
      xfer(1'b0, {8'h02, 8'h00, 8'h00}, 7, rd);
      check("R6 7-bit abort keeps rdy_n", {7'd0, rdy_n}, 8'h00);
      xfer(1'b1, {8'h02, 8'h00, 8'h00}, 8, rd);
      check("R6 8-bit abort clears rdy_n", {7'd0, rdy_n}, 8'h01);
      xfer(1'b0, {8'h02, 8'h00, 8'h00}, 16, rd);
      check("R5 lower byte second result", rd, 8'h34);

      // R7 partial writes
      xfer(1'b0, {8'h83, 8'h99, 8'h00}, 12, rd);
      xfer(1'b1, {8'h83, 8'h66, 8'h00}, 15, rd);
      xfer(1'b1, {8'h03, 8'h00, 8'h00}, 16, rd);
      check("R7 aborted writes leave 0x03", rd, 8'h00);

      // R8 trailing byte ignored
      xfer(1'b1, {8'h84, 8'h77, 8'h11}, 24, rd);
      xfer(1'b0, {8'h04, 8'h00, 8'h00}, 16, rd);
      check("R8 target holds first data byte", rd, 8'h77);
      xfer(1'b0, {8'h05, 8'h00, 8'h00}, 16, rd);
      check("R8 next address untouched", rd, 8'h3C);

      finish_run();
   end

endmodule